// File: doc/BRIEF.md
# Ripple Johnson Clock Divider

This block turns a fast clock into a very slow square wave by cascading small two-bit twisted-ring counters. Each stage divides its own clock by four. Every stage after the first is clocked by the high state bit of the stage in front of it, so the stages ripple instead of sharing one clock. With the default of twelve stages, the chain divides by 4^12 = 16,777,216. A 100 MHz input therefore gives an output of roughly 5.96 Hz, which is below 10 Hz.

The output is the high bit of the last stage. No intermediate stage is brought out of the block. The reset input is asynchronous and active low. Asserting it clears the whole chain at once. Its removal is passed through a short synchronizer on the input clock, so the first stage always starts counting on a defined input edge.

Top module: `ripple_johnson_div`

## Requirements
- R1: In steady operation, `clk_out` rises once every 4^N_STAGES rising edges of `clk_in`.
- R2: Each stage state, written {high bit, low bit}, steps only as 00 → 01 → 11 → 10 → 00. A stage never flips both bits at once and never moves backwards.
- R3: Once released from reset, the first stage advances on every rising edge of `clk_in`.
- R4: While `rst_n` is low, every stage holds 00 and `clk_out` is 0. Driving `rst_n` low forces `clk_out` to 0 at once, without waiting for a clock edge.
- R5: A stage other than the first changes state only when the high bit of the preceding stage has risen since the previous `clk_in` edge.
- R6: The release of `rst_n` passes through SYNC_STAGES (default 2) flops clocked by `clk_in`. The first stage makes its first step on rising edge SYNC_STAGES+1 after `rst_n` goes high. `clk_out` first rises on edge SYNC_STAGES + (4^N_STAGES+2)/3 after release.
- R7: `clk_out` has a 50% duty cycle. It stays high for exactly 2·4^(N_STAGES−1) input edges and low for the same number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized to `clk_in` |
| clk_out | output | 1 | Divided output, the high bit of the last stage |

## Verification
The bound checker looks inside the chain on every input clock edge. It confirms four things:
- every stage takes only legal twisted-ring steps;
- the first stage moves on every edge once released;
- a later stage moves only after its upstream high bit rises;
- the whole chain is zero while reset is held.

The output period, the 50% duty cycle, the exact latency from reset release to the first output rise, and the asynchronous clearing of the output can only be seen at the port. The bench shows these by comparing `clk_out` against a counting model in every cycle, with a shortened chain, across a reset applied in the middle of a run.

// File: rtl/rjd_pkg.sv
package rjd_pkg;

  // Twisted-ring stage states, written {high, low}
  typedef enum logic [1:0] {
    RING_S0 = 2'b00,
    RING_S1 = 2'b01,
    RING_S2 = 2'b11,
    RING_S3 = 2'b10
  } ring_state_e;

  // One step of a two-bit ring with one inversion in its feedback
  function automatic ring_state_e ring_step(input ring_state_e cur);
    logic [1:0] raw;
    raw = cur;
    return ring_state_e'({raw[0], ~raw[1]});
  endfunction

endpackage

// File: rtl/rjd_reset_sync.sv
module rjd_reset_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [SYNC_STAGES-1:0] shreg;
  logic [SYNC_STAGES-1:0] shreg_nxt;

  always_comb begin
    shreg_nxt = (shreg << 1) | SYNC_STAGES'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= shreg_nxt;
  end

  assign rst_sync_n = shreg[SYNC_STAGES-1];

endmodule

// File: rtl/rjd_stage.sv
module rjd_stage
  import rjd_pkg::*;
(
  input  logic       stage_clk,
  input  logic       rst_n,
  output logic [1:0] q
);

  ring_state_e st;
  ring_state_e st_nxt;

  always_comb begin
    st_nxt = ring_step(st);
  end

  always_ff @(posedge stage_clk or negedge rst_n) begin
    if (!rst_n) st <= RING_S0;
    else        st <= st_nxt;
  end

  assign q = st;

endmodule

// File: rtl/rjd_chain.sv
module rjd_chain #(
  parameter int N_STAGES = 12
) (
  input  logic                  clk_in,
  input  logic                  rst_n,
  output logic [2*N_STAGES-1:0] chain_q
);

  localparam int STATE_W = 2 * N_STAGES;

  logic [N_STAGES-1:0] tick;
  logic [STATE_W-1:0]  q_all;

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign tick[k] = clk_in;
    end else begin : g_tail
      assign tick[k] = q_all[2*(k-1)+1];
    end

    rjd_stage u_stage (
      .stage_clk (tick[k]),
      .rst_n     (rst_n),
      .q         (q_all[2*k +: 2])
    );
  end

  assign chain_q = q_all;

endmodule

// File: rtl/ripple_johnson_div.sv
module ripple_johnson_div #(
  parameter int N_STAGES    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_in,
  input  logic rst_n,
  output logic clk_out
);

  localparam int STATE_W = 2 * N_STAGES;

  logic               rst_sync_n;
  logic [STATE_W-1:0] chain_q;

  rjd_reset_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk_in),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rjd_chain #(.N_STAGES(N_STAGES)) u_chain (
    .clk_in  (clk_in),
    .rst_n   (rst_sync_n),
    .chain_q (chain_q)
  );

  assign clk_out = chain_q[STATE_W-1];

endmodule

// File: rtl/ripple_johnson_div_chk.sv
module ripple_johnson_div_chk #(
  parameter int N_STAGES = 12
) (
  input logic                  clk_in,
  input logic                  rst_sync_n,
  input logic [2*N_STAGES-1:0] chain_q
);

  // Allowed moves, listed explicitly
  function automatic logic move_ok(input logic [1:0] from_s, input logic [1:0] to_s);
    case ({from_s, to_s})
      4'b00_01, 4'b01_11, 4'b11_10, 4'b10_00: return 1'b1;
      default:                                return 1'b0;
    endcase
  endfunction

  // R4: chain fully cleared while reset is applied
  a_r4_chain_clear: assert property (@(posedge clk_in)
    !rst_sync_n |-> (chain_q == '0));

  // R3: first stage moves on every edge once it is out of reset
  a_r3_head_moves: assert property (@(posedge clk_in) disable iff (!rst_sync_n)
    $past(rst_sync_n) |-> (chain_q[1:0] != $past(chain_q[1:0])));

  for (genvar k = 0; k < N_STAGES; k++) begin : g_chk
    // R2: any observed change is one legal ring step
    a_r2_legal_step: assert property (@(posedge clk_in) disable iff (!rst_sync_n)
      (chain_q[2*k +: 2] != $past(chain_q[2*k +: 2]))
        |-> move_ok($past(chain_q[2*k +: 2]), chain_q[2*k +: 2]));

    // R2: never both bits in one interval
    a_r2_one_bit: assert property (@(posedge clk_in) disable iff (!rst_sync_n)
      $countones(chain_q[2*k +: 2] ^ $past(chain_q[2*k +: 2])) <= 1);

    if (k > 0) begin : g_ripple
      // R5: downstream stage moves only after upstream high bit rises
      a_r5_ripple_cause: assert property (@(posedge clk_in) disable iff (!rst_sync_n)
        (chain_q[2*k +: 2] != $past(chain_q[2*k +: 2])) |-> $rose(chain_q[2*k-1]));
    end
  end

endmodule

bind ripple_johnson_div ripple_johnson_div_chk #(.N_STAGES(N_STAGES)) u_chk (
  .clk_in     (clk_in),
  .rst_sync_n (rst_sync_n),
  .chain_q    (chain_q)
);

// File: tb/ripple_johnson_div_tb.sv
module ripple_johnson_div_tb;

  localparam int     NS      = 4;
  localparam int     SY      = 2;
  localparam longint HALF    = 2 * (4 ** (NS - 1));
  localparam longint FIRST_R = SY + ((4 ** NS) + 2) / 3;

  logic clk_in = 1'b0;
  logic rst_n;
  logic clk_out;

  int     checks = 0;
  int     errors = 0;
  int     cyc    = 0;
  longint edges  = 0;

  ripple_johnson_div #(.N_STAGES(NS), .SYNC_STAGES(SY)) u_dut (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .clk_out (clk_out)
  );

  always #10 clk_in = ~clk_in;

  // Behavioural model: stage k counts how often stage k-1 reached phase 2
  function automatic logic model_out(input longint e);
    longint c;
    c = (e > SY) ? e - SY : 0;
    for (int k = 1; k < NS; k++) c = (c + 2) / 4;
    return (c % 4) >= 2;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk_in) begin
    if (rst_n) edges++;
    else       edges = 0;
  end

  // Per-cycle comparison plus period / duty measurement
  logic   prev_out  = 1'b0;
  bit     have_rise = 0;
  bit     first_pend = 1;
  longint last_rise = 0;

  always @(negedge clk_in) begin
    logic exp_o;
    #2;
    exp_o = rst_n ? model_out(edges) : 1'b0;
    check(clk_out === exp_o, "R1 R2 R3 R5 R6 model", longint'(clk_out), longint'(exp_o));
    if (!rst_n) begin
      have_rise  = 0;
      first_pend = 1;
    end else begin
      if (clk_out && !prev_out) begin
        if (first_pend) begin
          check(edges == FIRST_R, "R6 first rise latency", edges, FIRST_R);
          first_pend = 0;
        end
        if (have_rise)
          check(edges - last_rise == 2 * HALF, "R1 period", edges - last_rise, 2 * HALF);
        have_rise = 1;
        last_rise = edges;
      end
      if (!clk_out && prev_out && have_rise)
        check(edges - last_rise == HALF, "R7 high time", edges - last_rise, HALF);
    end
    prev_out = clk_out;
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk_in) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 100000);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (4) @(negedge clk_in);
    #3;
    check(clk_out === 1'b0, "R4 reset state", longint'(clk_out), 0);
    @(negedge clk_in);
    rst_n = 1'b1;
    repeat (1100) @(negedge clk_in);
    // Apply reset between edges while the output is high
    while (clk_out !== 1'b1) @(negedge clk_in);
    #5 rst_n = 1'b0;
    #1;
    check(clk_out === 1'b0, "R4 async clear", longint'(clk_out), 0);
    repeat (3) @(negedge clk_in);
    rst_n = 1'b1;
    repeat (700) @(negedge clk_in);
    finish_run();
  end

endmodule